// File: doc/BRIEF.md
# I2C Master Write Controller

This block is a bus master that writes a burst of bytes to one target on a two-wire serial bus. A request gives the target's 7-bit address with the direction bit in bit 0, and a byte count. The engine first checks the parameters. It then confirms the bus has been idle for a full window and raises a START. It shifts the address byte out, followed by the data bytes, which it pulls one at a time from a valid/ready stream. It closes the transfer with a STOP. At the end it returns a one-byte status code and the number of data bytes the target acknowledged.

Both bus lines are open drain. The block drives them only through active-high pull-low enables and never drives a line high. The clock and data line levels come back through two-flop synchronizers. The engine waits for the clock line to rise before it times a high phase, so a target can slow the clock, and a watchdog bounds that wait. On every transmitted 1 it checks whether another master owns the data line. All interval lengths are cycle counts derived from the system clock frequency.

Status codes:

| Code | Meaning |
|------|---------|
| 0x00 | Transfer completed |
| 0x01 | Bus busy |
| 0x02 | Address not acknowledged |
| 0x04 | Data byte not acknowledged |
| 0x08 | Arbitration lost |
| 0x10 | Clock-stretch timeout |
| 0x20 | Direction bit set |
| 0x40 | Byte count too large |

Top module: `iic_write_engine`

## Requirements
- R1: A request whose `req_addr[0]` is 1 ends with status 0x20. `done` rises in the cycle after the request is accepted, and neither pull enable is ever asserted. This check takes priority over the length check.
- R2: A request whose `req_len` is above 255 and whose direction bit is 0 ends with status 0x40. It has the same one-cycle timing as R1 and leaves the bus untouched.
- R3: If either synchronized line is seen low during the idle window of `IDLE_CYC` cycles, the request ends with status 0x01. No pull enable is asserted.
- R4: A START pulls SDA low while SCL is released. SCL then stays high for at least `HOLD_CYC` cycles before its first falling edge.
- R5: The address byte goes out first, then exactly `req_len` data bytes in stream order. Each byte is sent MSB first. A byte is consumed only on a cycle where `wr_valid` and `wr_ready` are both high.
- R6: After SCL is released, the high phase is timed only from the moment SCL is observed high. A target that holds SCL low for less than `STRETCH_CYC` cycles slows the transfer but does not change its result.
- R7: If SDA reads low during an SCL high phase in which the engine is sending a 1, the engine ends at once with status 0x08. Both lines are released and no STOP is issued.
- R8: A high SDA during the acknowledge high phase of the address byte gives status 0x02 with a count of 0. On a data byte it gives status 0x04, with `sent_count` equal to the data bytes acknowledged before it. A STOP follows in both cases. `sent_count` grows by one only after an acknowledged data byte.
- R9: A STOP drives SCL low, then pulls SDA low, releases SCL, waits for SCL high plus `HOLD_CYC` cycles, then releases SDA. A full transfer then reports status 0x00 with `sent_count` equal to `req_len`. `done` is a one-cycle pulse, and both pull enables are off while it is high.
- R10: If SCL is not seen high within `STRETCH_CYC` cycles of its release, both lines are released and status 0x10 is reported.
- R11: Outside the START, the STOP and abort releases, the SDA pull enable changes only while SCL is pulled low. Each completed transfer therefore shows exactly one START and one STOP on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_addr | input | 8 | Target address in bits 7:1, direction bit in bit 0 |
| req_len | input | 9 | Number of data bytes |
| wr_data | input | 8 | Next data byte of the stream |
| wr_valid | input | 1 | `wr_data` is valid |
| wr_ready | output | 1 | Engine takes `wr_data` in this cycle |
| scl_i | input | 1 | Level seen on the clock line |
| sda_i | input | 1 | Level seen on the data line |
| scl_pull | output | 1 | Pull the clock line low |
| sda_pull | output | 1 | Pull the data line low |
| done | output | 1 | One-cycle end-of-request pulse |
| status | output | 8 | Result code, held until the next request ends |
| sent_count | output | 8 | Data bytes acknowledged, valid with `done` |

## Verification
Parameter rejections are registered straight into the final state, so `done` and the status are due exactly one clock after the accepting edge, and the bench samples them at the very next falling edge. A busy bus is reported within the two synchronizer stages plus one state step. Every bus result depends on stretching, arbitration and acknowledge timing. For these the bench does not count cycles: it waits, with a bound, for the `done` pulse and reads status, count and the bus-side log at the falling edge where `done` is high. The target model samples the lines on falling clock edges, so it always sees values the engine registered on the preceding rising edge.

// File: rtl/iic_pkg.sv
package iic_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_FREE, S_START,
    S_BLO1, S_BLO2, S_BRISE, S_BHI,
    S_ALO1, S_ALO2, S_ARISE, S_AHI,
    S_FETCH,
    S_PLO1, S_PLO2, S_PRISE, S_PWAIT, S_PSDA,
    S_FIN
  } eng_state_t;

  localparam logic [7:0] RC_OK     = 8'h00;
  localparam logic [7:0] RC_BUSY   = 8'h01;
  localparam logic [7:0] RC_ANACK  = 8'h02;
  localparam logic [7:0] RC_DNACK  = 8'h04;
  localparam logic [7:0] RC_ARB    = 8'h08;
  localparam logic [7:0] RC_TMO    = 8'h10;
  localparam logic [7:0] RC_BADDIR = 8'h20;
  localparam logic [7:0] RC_BADLEN = 8'h40;

endpackage

// File: rtl/iic_sync.sv
module iic_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // Two flops per line; lines idle high so reset value is 1.
  for (genvar g = 0; g < W; g++) begin : g_line
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
      end else begin
        meta_q <= d[g];
        sync_q <= meta_q;
      end
    end
    assign q[g] = sync_q;
  end

endmodule

// File: rtl/iic_timer.sv
module iic_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)            cnt_d = len;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/iic_write_engine.sv
module iic_write_engine
  import iic_pkg::*;
#(
  parameter int CLK_KHZ     = 125000,
  parameter int BUS_KHZ     = 100,
  parameter int MAX_LEN     = 255,
  parameter int HALF_CYC    = CLK_KHZ / (4 * BUS_KHZ),
  parameter int HOLD_CYC    = (CLK_KHZ * 47 + 9999) / 10000,
  parameter int IDLE_CYC    = HOLD_CYC,
  parameter int STRETCH_CYC = CLK_KHZ * 10,
  localparam int LW         = $clog2(MAX_LEN + 2),
  localparam int CW         = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [7:0]    req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [7:0]    wr_data,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_pull,
  output logic          sda_pull,
  output logic          done,
  output logic [7:0]    status,
  output logic [CW-1:0] sent_count
);

  localparam int TSPAN = HALF_CYC + HOLD_CYC + IDLE_CYC + STRETCH_CYC;
  localparam int TW    = $clog2(TSPAN + 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  // line synchronizers
  logic [1:0] line_s;
  logic       scl_s, sda_s;
  iic_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .d     ({scl_i, sda_i}),
    .q     (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  // shared interval timer
  logic          t_load, t_exp;
  logic [TW-1:0] t_len;
  iic_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_q),
    .load    (t_load),
    .len     (t_len),
    .expired (t_exp)
  );

  eng_state_t    st_q, st_d;
  logic [7:0]    sh_q, sh_d;
  logic [2:0]    bit_q, bit_d;
  logic [LW-1:0] left_q, left_d;
  logic [CW-1:0] sent_q, sent_d;
  logic          is_addr_q, is_addr_d;
  logic [7:0]    stat_q, stat_d;
  logic [7:0]    pend_q, pend_d;
  logic          scl_pull_q, scl_pull_d;
  logic          sda_pull_q, sda_pull_d;

  always_comb begin
    st_d       = st_q;
    sh_d       = sh_q;
    bit_d      = bit_q;
    left_d     = left_q;
    sent_d     = sent_q;
    is_addr_d  = is_addr_q;
    stat_d     = stat_q;
    pend_d     = pend_q;
    scl_pull_d = scl_pull_q;
    sda_pull_d = sda_pull_q;
    t_load     = 1'b0;
    t_len      = '0;
    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          sent_d = '0;
          if (req_addr[0]) begin
            stat_d = RC_BADDIR;
            st_d   = S_FIN;
          end else if (req_len > LW'(MAX_LEN)) begin
            stat_d = RC_BADLEN;
            st_d   = S_FIN;
          end else begin
            sh_d      = req_addr;
            left_d    = req_len;
            is_addr_d = 1'b1;
            bit_d     = '0;
            t_load    = 1'b1;
            t_len     = TW'(IDLE_CYC);
            st_d      = S_FREE;
          end
        end
      end
      S_FREE: begin
        if (!scl_s || !sda_s) begin
          stat_d = RC_BUSY;
          st_d   = S_FIN;
        end else if (t_exp) begin
          sda_pull_d = 1'b1;
          t_load     = 1'b1;
          t_len      = TW'(HOLD_CYC);
          st_d       = S_START;
        end
      end
      S_START: begin
        if (t_exp) begin
          scl_pull_d = 1'b1;
          t_load     = 1'b1;
          t_len      = TW'(HALF_CYC);
          st_d       = S_BLO1;
        end
      end
      S_BLO1: begin
        if (t_exp) begin
          sda_pull_d = ~sh_q[7];
          t_load     = 1'b1;
          t_len      = TW'(HALF_CYC);
          st_d       = S_BLO2;
        end
      end
      S_BLO2: begin
        if (t_exp) begin
          scl_pull_d = 1'b0;
          t_load     = 1'b1;
          t_len      = TW'(STRETCH_CYC);
          st_d       = S_BRISE;
        end
      end
      S_BRISE, S_ARISE: begin
        if (scl_s) begin
          t_load = 1'b1;
          t_len  = TW'(HOLD_CYC);
          st_d   = (st_q == S_BRISE) ? S_BHI : S_AHI;
        end else if (t_exp) begin
          scl_pull_d = 1'b0;
          sda_pull_d = 1'b0;
          stat_d     = RC_TMO;
          st_d       = S_FIN;
        end
      end
      S_BHI: begin
        if (!sda_pull_q && !sda_s) begin
          scl_pull_d = 1'b0;
          sda_pull_d = 1'b0;
          stat_d     = RC_ARB;
          st_d       = S_FIN;
        end else if (t_exp) begin
          scl_pull_d = 1'b1;
          t_load     = 1'b1;
          t_len      = TW'(HALF_CYC);
          sh_d       = {sh_q[6:0], 1'b0};
          bit_d      = bit_q + 1'b1;
          st_d       = (bit_q == 3'd7) ? S_ALO1 : S_BLO1;
        end
      end
      S_ALO1: begin
        if (t_exp) begin
          sda_pull_d = 1'b0;
          t_load     = 1'b1;
          t_len      = TW'(HALF_CYC);
          st_d       = S_ALO2;
        end
      end
      S_ALO2: begin
        if (t_exp) begin
          scl_pull_d = 1'b0;
          t_load     = 1'b1;
          t_len      = TW'(STRETCH_CYC);
          st_d       = S_ARISE;
        end
      end
      S_AHI: begin
        if (sda_s) begin
          pend_d     = is_addr_q ? RC_ANACK : RC_DNACK;
          scl_pull_d = 1'b1;
          t_load     = 1'b1;
          t_len      = TW'(HALF_CYC);
          st_d       = S_PLO1;
        end else if (t_exp) begin
          if (!is_addr_q) sent_d = sent_q + 1'b1;
          scl_pull_d = 1'b1;
          if (left_q == '0) begin
            pend_d = RC_OK;
            t_load = 1'b1;
            t_len  = TW'(HALF_CYC);
            st_d   = S_PLO1;
          end else begin
            st_d = S_FETCH;
          end
        end
      end
      S_FETCH: begin
        if (wr_valid) begin
          sh_d      = wr_data;
          left_d    = left_q - 1'b1;
          is_addr_d = 1'b0;
          bit_d     = '0;
          t_load    = 1'b1;
          t_len     = TW'(HALF_CYC);
          st_d      = S_BLO1;
        end
      end
      S_PLO1: begin
        if (t_exp) begin
          sda_pull_d = 1'b1;
          t_load     = 1'b1;
          t_len      = TW'(HOLD_CYC);
          st_d       = S_PLO2;
        end
      end
      S_PLO2: begin
        if (t_exp) begin
          scl_pull_d = 1'b0;
          t_load     = 1'b1;
          t_len      = TW'(STRETCH_CYC);
          st_d       = S_PRISE;
        end
      end
      S_PRISE: begin
        if (scl_s) begin
          t_load = 1'b1;
          t_len  = TW'(HOLD_CYC);
          st_d   = S_PWAIT;
        end else if (t_exp) begin
          sda_pull_d = 1'b0;
          stat_d     = RC_TMO;
          st_d       = S_FIN;
        end
      end
      S_PWAIT: begin
        if (t_exp) begin
          sda_pull_d = 1'b0;
          t_load     = 1'b1;
          t_len      = TW'(STRETCH_CYC);
          st_d       = S_PSDA;
        end
      end
      S_PSDA: begin
        if (sda_s) begin
          stat_d = pend_q;
          st_d   = S_FIN;
        end else if (t_exp) begin
          stat_d = RC_TMO;
          st_d   = S_FIN;
        end
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q       <= S_IDLE;
      sh_q       <= '0;
      bit_q      <= '0;
      left_q     <= '0;
      sent_q     <= '0;
      is_addr_q  <= 1'b0;
      stat_q     <= RC_OK;
      pend_q     <= RC_OK;
      scl_pull_q <= 1'b0;
      sda_pull_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      sh_q       <= sh_d;
      bit_q      <= bit_d;
      left_q     <= left_d;
      sent_q     <= sent_d;
      is_addr_q  <= is_addr_d;
      stat_q     <= stat_d;
      pend_q     <= pend_d;
      scl_pull_q <= scl_pull_d;
      sda_pull_q <= sda_pull_d;
    end
  end

  assign req_ready  = (st_q == S_IDLE);
  assign wr_ready   = (st_q == S_FETCH);
  assign done       = (st_q == S_FIN);
  assign status     = stat_q;
  assign sent_count = sent_q;
  assign scl_pull   = scl_pull_q;
  assign sda_pull   = sda_pull_q;

  // R1, R2
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == S_IDLE && req_valid && (req_addr[0] || req_len > LW'(MAX_LEN)))
      |=> (done && !scl_pull_q && !sda_pull_q));

  // R3
  free_hands_off_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == S_FREE) |-> (!scl_pull_q && !sda_pull_q));

  // R9
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done |-> (!scl_pull_q && !sda_pull_q));

  // R8
  sent_step_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((sent_q != $past(sent_q)) && ($past(st_q) != S_IDLE))
      |-> ($past(st_q) == S_AHI && sent_q == $past(sent_q) + 1'b1));

  // R11
  sda_order_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((sda_pull_q != $past(sda_pull_q)) && !$past(scl_pull_q))
      |-> ($past(st_q) inside {S_FREE, S_PWAIT, S_BRISE, S_PRISE}));

endmodule

// File: tb/iic_write_engine_tb.sv
module iic_write_engine_tb;

  localparam int HALF = 3;
  localparam int HOLD = 6;
  localparam int IDLE = 6;
  localparam int STRETCH = 60;

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 29 + i * 53 + 7) & 255);
  endfunction

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [7:0] req_addr;
  logic [8:0] req_len;
  logic [7:0] wr_data;
  logic       wr_valid;
  logic       wr_ready;
  logic       scl_pull, sda_pull, done;
  logic [7:0] status, sent_count;

  logic ext_scl_low, ext_sda_low;
  logic s_scl_hold = 1'b0;
  logic s_sda_ack  = 1'b0;
  logic rival_pull = 1'b0;

  wire scl_line = ~(scl_pull | s_scl_hold | ext_scl_low);
  wire sda_line = ~(sda_pull | s_sda_ack | rival_pull | ext_sda_low);

  int nack_at, stretch_n, rival_byte, rival_bit, cur_seed;
  logic feed_clr, mon_clr;
  int feed_idx = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (feed_clr) feed_idx <= 0;
    else if (wr_ready && wr_valid) feed_idx <= feed_idx + 1;
  end
  assign wr_data = pat(cur_seed, feed_idx);

  iic_write_engine #(
    .HALF_CYC(HALF), .HOLD_CYC(HOLD), .IDLE_CYC(IDLE), .STRETCH_CYC(STRETCH)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .done(done), .status(status), .sent_count(sent_count)
  );

  // target model, acting on falling clock edges
  int starts = 0, stops = 0, bitn = 0, byten = 0, hold_cnt = 0;
  int t_start = 0, gap = 0;
  logic want_gap = 1'b0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic [7:0] sh = 8'h00;
  logic [7:0] blog [0:15];
  logic any_pull = 1'b0;

  always @(negedge clk) begin : tgt
    logic c_scl, c_sda;
    c_scl = scl_line;
    c_sda = sda_line;
    if (hold_cnt > 0) hold_cnt = hold_cnt - 1;
    if (rival_byte < 0) rival_pull = 1'b0;
    if (p_scl && c_scl && p_sda && !c_sda) begin
      starts = starts + 1; bitn = 0; byten = 0; s_sda_ack = 1'b0;
      t_start = cyc; want_gap = 1'b1;
    end else if (p_scl && c_scl && !p_sda && c_sda) begin
      stops = stops + 1;
    end
    if (!p_scl && c_scl) begin
      if (bitn < 8) begin
        sh = {sh[6:0], c_sda};
        bitn = bitn + 1;
        if (bitn == 8 && byten < 16) blog[byten] = sh;
      end else begin
        bitn = 0;
        byten = byten + 1;
      end
    end
    if (p_scl && !c_scl) begin
      if (want_gap) begin gap = cyc - t_start; want_gap = 1'b0; end
      s_sda_ack = (bitn == 8) && (byten != nack_at);
      if (stretch_n > 0) hold_cnt = stretch_n;
      if (byten == rival_byte && bitn == rival_bit) rival_pull = 1'b1;
    end
    s_scl_hold = (hold_cnt > 0);
    p_scl = c_scl;
    p_sda = c_sda;
    if (mon_clr) any_pull = 1'b0;
    else if (scl_pull || sda_pull) any_pull = 1'b1;
  end

  int total = 0, bad = 0;
  logic over = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    int k = 0;
    while (k < 10) begin
      @(negedge clk);
      if (scl_line && sda_line) k++; else k = 0;
    end
  endtask

  task automatic send_req(input logic [7:0] a, input int len);
    @(negedge clk);
    mon_clr = 1'b1; feed_clr = 1'b1;
    req_valid = 1'b1; req_addr = a; req_len = 9'(len);
    @(negedge clk);
    mon_clr = 1'b0; feed_clr = 1'b0; req_valid = 1'b0;
  endtask

  task automatic reject(input logic [7:0] a, input int len, input int exp, input string tag);
    wait_idle();
    send_req(a, len);
    chk({tag, " done next cycle"}, int'(done), 1);
    chk({tag, " status"}, int'(status), exp);
    @(negedge clk);
    chk({tag, " done pulse ends"}, int'(done), 0);
    chk({tag, " bus untouched"}, int'(any_pull), 0);
  endtask

  task automatic run(input logic [7:0] a, input int len, input int seed,
                     input int exp_st, input int exp_sent, input int exp_stop,
                     input string tag);
    int s0, p0, n;
    wait_idle();
    s0 = starts; p0 = stops;
    cur_seed = seed;
    send_req(a, len);
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk({tag, " done seen"}, int'(done), 1);
    chk({tag, " status"}, int'(status), exp_st);
    chk({tag, " sent_count"}, int'(sent_count), exp_sent);
    chk({tag, " stop count"}, stops - p0, exp_stop);
    chk({tag, " lines released"}, int'(scl_pull | sda_pull), 0);
    if (exp_st == 0) begin
      // R11 one START per transfer, R4 START hold, R5 bytes in order
      chk({tag, " R11 start count"}, starts - s0, 1);
      chk({tag, " R4 start hold"}, int'(gap >= HOLD), 1);
      chk({tag, " R5 address byte"}, int'(blog[0]), int'(a));
      for (int i = 0; i < len && i < 15; i++)
        chk({tag, " R5 data byte"}, int'(blog[i+1]), int'(pat(seed, i)));
      chk({tag, " R5 stream use"}, feed_idx, len);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!over) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = 8'h00; req_len = 9'd0;
    wr_valid = 1'b1; ext_scl_low = 1'b0; ext_sda_low = 1'b0;
    nack_at = -1; stretch_n = 0; rival_byte = -1; rival_bit = 0; cur_seed = 0;
    feed_clr = 1'b0; mon_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("reset req_ready", int'(req_ready), 1);
    chk("reset pulls", int'(scl_pull | sda_pull), 0);
    chk("reset done", int'(done), 0);
    chk("reset status", int'(status), 0);

    // R1 direction bit, with and without a bad length
    reject(8'hA1, 2,   8'h20, "R1 dir");
    reject(8'h51, 300, 8'h20, "R1 priority");
    // R2 length above 255
    reject(8'hA0, 256, 8'h40, "R2 len256");
    reject(8'hFE, 511, 8'h40, "R2 len511");

    // R3 busy bus, clock then data held low
    for (int w = 0; w < 2; w++) begin
      ext_scl_low = (w == 0); ext_sda_low = (w == 1);
      repeat (5) @(negedge clk);
      send_req(8'hA0, 1);
      for (int n = 0; n < 10 && !done; n++) @(negedge clk);
      chk("R3 busy done", int'(done), 1);
      chk("R3 busy status", int'(status), 8'h01);
      chk("R3 bus untouched", int'(any_pull), 0);
      ext_scl_low = 1'b0; ext_sda_low = 1'b0;
    end

    // R9 sweep of addresses and lengths, R5 checked inside
    for (int ai = 0; ai < 3; ai++)
      for (int li = 0; li < 4; li++) begin
        int a7 = (ai == 0) ? 0 : (ai == 1) ? 8'h2A : 8'h7F;
        int ln = (li == 3) ? 5 : li;
        run(8'(a7 << 1), ln, ai * 4 + li, 0, ln, 1, "R9 sweep");
      end

    // R6 target stretches every low phase
    stretch_n = 20;
    run(8'h3C, 3, 21, 0, 3, 1, "R6 stretch");
    stretch_n = 0;

    // R8 address and data NACKs
    nack_at = 0;
    run(8'h90, 3, 5, 8'h02, 0, 1, "R8 addr nack");
    nack_at = 3;
    run(8'h90, 5, 6, 8'h04, 2, 1, "R8 data nack mid");
    nack_at = 5;
    run(8'h90, 5, 7, 8'h04, 4, 1, "R8 data nack last");
    nack_at = -1;

    // R7 rival master on the first and second address bits
    rival_byte = 0; rival_bit = 0;
    run(8'hA0, 2, 8, 8'h08, 0, 0, "R7 arb bit0");
    rival_byte = -1;
    repeat (3) @(negedge clk);
    rival_byte = 0; rival_bit = 1;
    run(8'hC0, 2, 9, 8'h08, 0, 0, "R7 arb bit1");
    rival_byte = -1;
    repeat (3) @(negedge clk);

    // R10 stretch longer than the limit
    stretch_n = 1000;
    run(8'h44, 1, 10, 8'h10, 0, 0, "R10 timeout");
    stretch_n = 0;

    // bus recovers after the timeout
    run(8'h44, 2, 11, 0, 2, 1, "R9 after timeout");

    over = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule